// File: doc/BRIEF.md
# Working register bank mapper

This block keeps an 8-bit pointer register and turns every register-file access into a physical bank number and an 8-bit offset. The high nibble of the pointer chooses one of sixteen 16-byte working groups. A short 4-bit working-register reference is expanded by placing that nibble in front of it. The low nibble of the pointer names an expanded bank. When it is non-zero, any access that lands in the bottom sixteen register addresses goes to that bank and not to the normal file.

The CPU reads and writes the pointer at one fixed register address. That address lies above the redirected window, so the pointer can be reached whatever bank is selected. Only some bank numbers exist. If the pointer selects a bank that does not exist, the block raises a flag on accesses to the bottom window. The storage then returns zero for reads and drops writes.

Top module: `regbank_mapper`

## Requirements
- R1: After synchronous reset the pointer is 00h, so a read at the pointer address returns 00h.
- R2: A write (`cpu_wr` high) with `cpu_addr` equal to FDh loads all eight bits of `cpu_wdata` into the pointer. While `cpu_addr` is FDh, `cpu_rdata` shows the pointer; at any other address it shows 00h.
- R3: A write to any address other than FDh leaves the pointer unchanged.
- R4: A pointer write takes effect at the next clock edge. A translation in the same cycle as the write still uses the old pointer value.
- R5: With `log_short` high, the physical offset is {pointer[7:4], log_addr[3:0]}, and log_addr[7:4] is ignored.
- R6: With `log_short` low, the physical offset equals `log_addr`.
- R7: When the physical offset is in 00h–0Fh, `phys_bank` equals pointer[3:0]. Bank 0 means the normal register file.
- R8: When the physical offset is 10h or above, `phys_bank` is 0. This includes the pointer address FDh.
- R9: `bank_void` is high when the offset is in 00h–0Fh and pointer[3:0] is not one of the implemented banks 0h, 1h, 2h, 3h, Dh, Fh.
- R10: `bank_void` is low for every offset of 10h or above and for every implemented bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 8 | Register address of the CPU pointer access |
| cpu_wr | input | 1 | Write strobe for the CPU access |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Pointer value when cpu_addr hits the pointer, else 00h |
| ptr_hit | output | 1 | cpu_addr equals the pointer address |
| log_addr | input | 8 | Logical register address, or a 4-bit reference in bits [3:0] |
| log_short | input | 1 | High when log_addr holds a 4-bit working-register reference |
| phys_bank | output | 4 | Physical bank of the access |
| phys_offset | output | 8 | Physical register offset |
| bank_void | output | 1 | The access falls in an unimplemented expanded bank |

## Verification
The assertions assume that `rst` is held for at least one edge before checks matter. They also assume `cpu_addr`, `cpu_wr` and the logical address are stable and known around each clock edge, because the mapping path is purely combinational from the registered pointer. The stimulus changes inputs only on the falling edge. Half of the pointer accesses are aimed at FDh and half of the logical addresses at the bottom window, so every bank value, void and non-void, gets exercised together with both address forms.

// File: rtl/rbm_pkg.sv
package rbm_pkg;
    localparam int ADDR_W = 8;
    localparam int NIB_W  = 4;
    localparam int NBANKS = 1 << NIB_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [NIB_W-1:0]  nib_t;

    typedef struct packed {
        nib_t  group;
        nib_t  bank;
    } ptr_t;

    typedef struct packed {
        nib_t  bank;
        addr_t offset;
        logic  void_sel;
    } map_t;

    function automatic logic in_low_window(addr_t a);
        return a[ADDR_W-1:NIB_W] == '0;
    endfunction
endpackage

// File: rtl/rbm_ptr_reg.sv
module rbm_ptr_reg
    import rbm_pkg::*;
#(
    parameter addr_t PTR_ADDR = 8'hFD
) (
    input  logic  clk,
    input  logic  rst,
    input  addr_t cpu_addr,
    input  logic  cpu_wr,
    input  addr_t cpu_wdata,
    output addr_t cpu_rdata,
    output logic  ptr_hit,
    output ptr_t  ptr_q
);
    assign ptr_hit = (cpu_addr == PTR_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (cpu_wr && ptr_hit) begin
            ptr_q <= ptr_t'(cpu_wdata);
        end
    end

    assign cpu_rdata = ptr_hit ? addr_t'(ptr_q) : '0;
endmodule

// File: rtl/rbm_addr_expand.sv
module rbm_addr_expand
    import rbm_pkg::*;
(
    input  ptr_t  ptr,
    input  addr_t log_addr,
    input  logic  log_short,
    output addr_t full_addr
);
    always_comb begin
        if (log_short) begin
            full_addr = {ptr.group, log_addr[NIB_W-1:0]};
        end else begin
            full_addr = log_addr;
        end
    end
endmodule

// File: rtl/rbm_bank_redirect.sv
module rbm_bank_redirect
    import rbm_pkg::*;
#(
    parameter logic [NBANKS-1:0] IMPL_MASK = 16'hA00F
) (
    input  ptr_t  ptr,
    input  addr_t full_addr,
    output map_t  map
);
    logic [NBANKS-1:0] sel_hot;
    logic              present;

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        assign sel_hot[b] = (ptr.bank == nib_t'(b)) && IMPL_MASK[b];
    end

    assign present = |sel_hot;

    always_comb begin
        map.offset = full_addr;
        if (in_low_window(full_addr)) begin
            map.bank     = ptr.bank;
            map.void_sel = !present;
        end else begin
            map.bank     = '0;
            map.void_sel = 1'b0;
        end
    end
endmodule

// File: rtl/regbank_mapper.sv
module regbank_mapper
    import rbm_pkg::*;
#(
    parameter addr_t             PTR_ADDR  = 8'hFD,
    parameter logic [NBANKS-1:0] IMPL_MASK = 16'hA00F
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] cpu_addr,
    input  logic       cpu_wr,
    input  logic [7:0] cpu_wdata,
    output logic [7:0] cpu_rdata,
    output logic       ptr_hit,
    input  logic [7:0] log_addr,
    input  logic       log_short,
    output logic [3:0] phys_bank,
    output logic [7:0] phys_offset,
    output logic       bank_void
);
    ptr_t  ptr_q;
    addr_t full_addr;
    map_t  map;

    rbm_ptr_reg #(.PTR_ADDR(PTR_ADDR)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .cpu_addr (cpu_addr),
        .cpu_wr   (cpu_wr),
        .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata),
        .ptr_hit  (ptr_hit),
        .ptr_q    (ptr_q)
    );

    rbm_addr_expand u_exp (
        .ptr      (ptr_q),
        .log_addr (log_addr),
        .log_short(log_short),
        .full_addr(full_addr)
    );

    rbm_bank_redirect #(.IMPL_MASK(IMPL_MASK)) u_redir (
        .ptr      (ptr_q),
        .full_addr(full_addr),
        .map      (map)
    );

    assign phys_bank   = map.bank;
    assign phys_offset = map.offset;
    assign bank_void   = map.void_sel;
endmodule

// File: rtl/rbm_checker.sv
module rbm_checker
    import rbm_pkg::*;
#(
    parameter addr_t PTR_ADDR = 8'hFD
) (
    input logic       clk,
    input logic       rst,
    input logic [7:0] cpu_addr,
    input logic       cpu_wr,
    input logic [7:0] cpu_wdata,
    input logic [7:0] log_addr,
    input logic       log_short,
    input logic [3:0] phys_bank,
    input logic [7:0] phys_offset,
    input logic       bank_void,
    input logic [7:0] ptr_q
);
    p_reset_zero_r1: assert property (@(posedge clk)
        rst |=> ptr_q == 8'h00);

    p_ptr_load_r2: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr == PTR_ADDR) |=> ptr_q == $past(cpu_wdata));

    p_ptr_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !(cpu_wr && cpu_addr == PTR_ADDR) |=> $stable(ptr_q));

    p_short_group_r5: assert property (@(posedge clk) disable iff (rst)
        log_short |-> (phys_offset[7:4] == ptr_q[7:4] && phys_offset[3:0] == log_addr[3:0]));

    p_long_pass_r6: assert property (@(posedge clk) disable iff (rst)
        !log_short |-> phys_offset == log_addr);

    p_low_bank_r7: assert property (@(posedge clk) disable iff (rst)
        (phys_offset[7:4] == 4'h0) |-> phys_bank == ptr_q[3:0]);

    p_high_bank0_r8: assert property (@(posedge clk) disable iff (rst)
        (phys_offset[7:4] != 4'h0) |-> phys_bank == 4'h0);

    p_void_low_r10: assert property (@(posedge clk) disable iff (rst)
        bank_void |-> (phys_offset[7:4] == 4'h0 && phys_bank != 4'h0));
endmodule

bind regbank_mapper rbm_checker #(.PTR_ADDR(PTR_ADDR)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cpu_addr   (cpu_addr),
    .cpu_wr     (cpu_wr),
    .cpu_wdata  (cpu_wdata),
    .log_addr   (log_addr),
    .log_short  (log_short),
    .phys_bank  (phys_bank),
    .phys_offset(phys_offset),
    .bank_void  (bank_void),
    .ptr_q      (ptr_q)
);

// File: tb/regbank_mapper_bench.sv
module regbank_mapper_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] PADDR = 8'hFD;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] cpu_addr = '0;
    logic       cpu_wr = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       ptr_hit;
    logic [7:0] log_addr = '0;
    logic       log_short = 1'b0;
    logic [3:0] phys_bank;
    logic [7:0] phys_offset;
    logic       bank_void;

    int checks = 0;
    int errors = 0;
    logic [7:0] mptr = '0;
    bit prev_miss = 1'b0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    regbank_mapper u_regbank_mapper (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .ptr_hit(ptr_hit),
        .log_addr(log_addr), .log_short(log_short), .phys_bank(phys_bank),
        .phys_offset(phys_offset), .bank_void(bank_void)
    );

    function automatic bit bank_exists(logic [3:0] b);
        return b inside {4'h0, 4'h1, 4'h2, 4'h3, 4'hD, 4'hF};
    endfunction

    function automatic logic [7:0] exp_offset(logic [7:0] p, logic [7:0] la, bit sh);
        return sh ? {p[7:4], la[3:0]} : la;
    endfunction

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [7:0] a, input bit wr, input logic [7:0] wd,
                         input logic [7:0] la, input bit sh);
        logic [7:0] off;
        logic [3:0] bk;
        bit         vd;
        @(negedge clk);
        cpu_addr = a; cpu_wr = wr; cpu_wdata = wd; log_addr = la; log_short = sh;
        #1;
        off = exp_offset(mptr, la, sh);
        bk  = (off[7:4] == 4'h0) ? mptr[3:0] : 4'h0;
        vd  = (off[7:4] == 4'h0) && !bank_exists(mptr[3:0]);
        chk(cpu_rdata, (a == PADDR) ? mptr : 8'h00, prev_miss ? "R3" : "R2");
        chk(phys_offset, off, sh ? "R5" : "R6");
        if (wr && a == PADDR)
            chk({4'h0, phys_bank}, {4'h0, bk}, "R4");
        else
            chk({4'h0, phys_bank}, {4'h0, bk}, (off[7:4] == 4'h0) ? "R7" : "R8");
        chk({7'h0, bank_void}, {7'h0, vd}, vd ? "R9" : "R10");
        prev_miss = wr && a != PADDR;
        if (wr && a == PADDR) mptr = wd;
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        cpu_addr = PADDR;
        #1;
        chk(cpu_rdata, 8'h00, "R1");
        // directed: each bank value against the low window, both forms
        for (int b = 0; b < 16; b++) begin
            apply(PADDR, 1'b1, {4'h0, 4'(b)}, 8'h00, 1'b0);
            apply(PADDR, 1'b0, 8'h00, 8'h0F, 1'b0);
            apply(8'h10, 1'b0, 8'h00, 8'h10, 1'b0);
            apply(PADDR, 1'b0, 8'h00, 8'hF7, 1'b1);
        end
        // R3: write to a neighbour address must not move the pointer
        apply(PADDR, 1'b1, 8'h5D, 8'h03, 1'b0);
        apply(8'hFC, 1'b1, 8'hAA, 8'h03, 1'b0);
        apply(PADDR, 1'b0, 8'h00, 8'h03, 1'b0);
        apply(8'hFE, 1'b1, 8'h11, 8'hFD, 1'b0);
        apply(PADDR, 1'b0, 8'h00, 8'hFD, 1'b0);
        // R5: group 0 with short form lands in the low window
        apply(PADDR, 1'b1, 8'h04, 8'h00, 1'b0);
        apply(PADDR, 1'b0, 8'h00, 8'hE9, 1'b1);
        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] a, la;
            a  = ($urandom % 2) ? PADDR : 8'($urandom);
            la = ($urandom % 2) ? 8'($urandom % 16) : 8'($urandom);
            apply(a, 1'($urandom), 8'($urandom), la, 1'($urandom));
        end
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule